// File: doc/BRIEF.md
# Bit Scan and Bit Count Execution Unit

This unit runs the bit-search and bit-count family of integer operations on one source operand that is 16, 32 or 64 bits wide. A three-way opcode family select picks the operation: lowest-set-bit search, highest-set-bit search, or population count. A prefix class and three feature enables then decide two things. For the two search families, they decide whether the instruction keeps its legacy bit-index meaning or becomes a zero-count. For population count, they decide whether the instruction is legal at all. Before any operation, the source is cut down to the operand width, and bits above that width are ignored.

Results come out one clock after the input strobe. With the result come a destination write enable, a zero flag, a carry flag and an illegal-operation indication. A small state machine has two states. ST_IDLE means no result is pending. ST_DONE means the registered outputs hold a fresh result. The transition IDLE->DONE or DONE->DONE is taken on a cycle with `valid_in` high. The transition DONE->IDLE or IDLE->IDLE is taken on a cycle without it. `out_valid` is high exactly in ST_DONE.

For a bit search on a zero operand, the unit returns the old destination value so the register stays unchanged. The two zero-counts return the operand width in that case.

Top module: `bitscan_unit`

## Requirements
- R1: `size` encodes the width as 2'b01 = 16, 2'b10 = 32 and 2'b11 = 64 bits. Source bits at or above the width are ignored. `size` = 2'b00 is an illegal operation.
- R2: Outputs are registered. `out_valid` rises in the cycle after `valid_in` is sampled high. `wr_en` is 1 with every legal result and 0 whenever `out_valid` is 0.
- R3: Forward search (`op_sel` = 2'b00, run as a search) returns the index of the lowest set bit. `zf` is 1 exactly when the masked source is zero.
- R4: Reverse search (`op_sel` = 2'b01, run as a search) returns the index of the highest set bit, not a leading-zero count. `zf` follows the masked source being zero.
- R5: A search whose masked source is zero returns `dst_old` masked to the operand width, with `zf` = 1 and `wr_en` = 1.
- R6: `op_sel` = 2'b00 with `pfx` = 2'b10 (repeat prefix) and `feat_tz` = 1 is a trailing-zero count. A zero source gives the width. `cf` = (source zero) and `zf` = (result zero).
- R7: `op_sel` = 2'b01 with `pfx` = 2'b10 and `feat_lz` = 1 is a leading-zero count within the width. A zero source gives the width. Flags follow R6.
- R8: Under any other prefix class (2'b00 none, 2'b01 operand-size, 2'b11 repeat-not-equal), or with the matching feature off, `op_sel` 2'b00 and 2'b01 remain searches.
- R9: `op_sel` = 2'b10 with `pfx` = 2'b10 and `feat_pop` = 1 returns the number of set bits. `zf` = (source zero) and `cf` = 0.
- R10: Population count under any other prefix or with `feat_pop` = 0, `op_sel` = 2'b11, and `size` = 2'b00 all raise `illegal`. In that case `wr_en` = 0, `result` = 0 and both flags are 0.
- R11: A flag that an operation does not define is driven to 0. In particular, `cf` is 0 for searches and for population count.
- R12: The state machine moves to ST_DONE on every cycle with `valid_in` high and to ST_IDLE on every cycle without it. After reset it is in ST_IDLE, with `out_valid` and `wr_en` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Operation strobe |
| op_sel | input | 2 | 00 forward family, 01 reverse family, 10 population count, 11 unused |
| size | input | 2 | Operand width code |
| pfx | input | 2 | Prefix class: 00 none, 01 operand-size, 10 repeat, 11 repeat-not-equal |
| feat_tz | input | 1 | Trailing-zero count enabled |
| feat_lz | input | 1 | Leading-zero count enabled |
| feat_pop | input | 1 | Population count enabled |
| src | input | 64 | Source operand |
| dst_old | input | 64 | Current destination register value |
| out_valid | output | 1 | Registered result present |
| wr_en | output | 1 | Destination write enable |
| result | output | 64 | Value for the destination |
| zf | output | 1 | Zero flag |
| cf | output | 1 | Carry flag |
| illegal | output | 1 | Illegal-operation indication |

## Verification
The bench sweeps every opcode family, prefix class and feature combination. For each width it places a single set bit at every position, uses zero and all-ones operands, and adds pseudo-random values. Junk is placed above the operand width to catch a missing mask, which would show up as a wrong index or a count beyond the width. Zero operands separate the two zero behaviours. A search that fails to keep `dst_old` would write garbage. A count that fails to return the width would return 0 or the index limit. A swapped flag convention would put the zero indication on `cf` instead of `zf`. The prefix and feature sweep catches a count that fires without the repeat prefix, and a population count that executes when it should be illegal.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
    typedef enum logic [2:0] {
        V_FSCAN, V_RSCAN, V_TZCNT, V_LZCNT, V_POPC, V_ILL
    } variant_t;

    typedef enum logic {ST_IDLE, ST_DONE} state_t;

    localparam logic [1:0] OP_FWD  = 2'b00;
    localparam logic [1:0] OP_REV  = 2'b01;
    localparam logic [1:0] OP_POP  = 2'b10;
    localparam logic [1:0] PFX_REP = 2'b10;
endpackage

// File: rtl/bsc_decode.sv
module bsc_decode
    import bsc_pkg::*;
(
    input  logic [1:0] op_sel,
    input  logic [1:0] size,
    input  logic [1:0] pfx,
    input  logic       feat_tz,
    input  logic       feat_lz,
    input  logic       feat_pop,
    output variant_t   variant
);
    logic rep;
    assign rep = (pfx == PFX_REP);

    always_comb begin
        if (size == 2'b00) begin
            variant = V_ILL;
        end else begin
            unique case (op_sel)
                OP_FWD:  variant = (rep && feat_tz)  ? V_TZCNT : V_FSCAN;
                OP_REV:  variant = (rep && feat_lz)  ? V_LZCNT : V_RSCAN;
                OP_POP:  variant = (rep && feat_pop) ? V_POPC  : V_ILL;
                default: variant = V_ILL;
            endcase
        end
    end
endmodule

// File: rtl/bsc_zext.sv
module bsc_zext #(
    parameter int DATA_W = 64,
    parameter int CNT_W  = $clog2(DATA_W) + 1
) (
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] dst_in,
    output logic [DATA_W-1:0] src_m,
    output logic [DATA_W-1:0] dst_m,
    output logic [CNT_W-1:0]  width
);
    logic [DATA_W-1:0] mask;

    always_comb begin
        unique case (size)
            2'b01:   width = CNT_W'(DATA_W / 4);
            2'b10:   width = CNT_W'(DATA_W / 2);
            2'b11:   width = CNT_W'(DATA_W);
            default: width = '0;
        endcase
        if (width == CNT_W'(DATA_W)) mask = '1;
        else                         mask = (DATA_W'(1) << width) - DATA_W'(1);
    end

    assign src_m = src & mask;
    assign dst_m = dst_in & mask;
endmodule

// File: rtl/bsc_bitops.sv
module bsc_bitops #(
    parameter int DATA_W = 64,
    parameter int CNT_W  = $clog2(DATA_W) + 1
) (
    input  logic [DATA_W-1:0] x,
    output logic [CNT_W-1:0]  lo_idx,
    output logic [CNT_W-1:0]  hi_idx,
    output logic [CNT_W-1:0]  ones,
    output logic              any
);
    always_comb begin
        lo_idx = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (x[i]) lo_idx = CNT_W'(i);
        end
        hi_idx = '0;
        for (int j = 0; j < DATA_W; j++) begin
            if (x[j]) hi_idx = CNT_W'(j);
        end
        ones = '0;
        for (int k = 0; k < DATA_W; k++) begin
            ones = ones + CNT_W'(x[k]);
        end
    end

    assign any = |x;
endmodule

// File: rtl/bitscan_unit.sv
module bitscan_unit
    import bsc_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int CNT_W = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  logic [1:0]        op_sel,
    input  logic [1:0]        size,
    input  logic [1:0]        pfx,
    input  logic              feat_tz,
    input  logic              feat_lz,
    input  logic              feat_pop,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] dst_old,
    output logic              out_valid,
    output logic              wr_en,
    output logic [DATA_W-1:0] result,
    output logic              zf,
    output logic              cf,
    output logic              illegal
);
    variant_t          variant;
    state_t            state_q, state_d;
    logic [DATA_W-1:0] src_m, dst_m;
    logic [CNT_W-1:0]  width, lo_idx, hi_idx, ones;
    logic              any;
    logic [DATA_W-1:0] res_d;
    logic              zf_d, cf_d, ill_d;

    bsc_decode u_dec (
        .op_sel(op_sel), .size(size), .pfx(pfx),
        .feat_tz(feat_tz), .feat_lz(feat_lz), .feat_pop(feat_pop),
        .variant(variant)
    );

    bsc_zext #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_zext (
        .size(size), .src(src), .dst_in(dst_old),
        .src_m(src_m), .dst_m(dst_m), .width(width)
    );

    bsc_bitops #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ops (
        .x(src_m), .lo_idx(lo_idx), .hi_idx(hi_idx), .ones(ones), .any(any)
    );

    always_comb begin
        res_d = '0;
        zf_d  = 1'b0;
        cf_d  = 1'b0;
        ill_d = 1'b0;
        unique case (variant)
            V_FSCAN: begin
                res_d = any ? DATA_W'(lo_idx) : dst_m;
                zf_d  = !any;
            end
            V_RSCAN: begin
                res_d = any ? DATA_W'(hi_idx) : dst_m;
                zf_d  = !any;
            end
            V_TZCNT: begin
                res_d = any ? DATA_W'(lo_idx) : DATA_W'(width);
                cf_d  = !any;
                zf_d  = (res_d == '0);
            end
            V_LZCNT: begin
                res_d = any ? DATA_W'(width - CNT_W'(1) - hi_idx) : DATA_W'(width);
                cf_d  = !any;
                zf_d  = (res_d == '0);
            end
            V_POPC: begin
                res_d = DATA_W'(ones);
                zf_d  = !any;
            end
            default: ill_d = 1'b1;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = valid_in ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = valid_in ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            result  <= '0;
            zf      <= 1'b0;
            cf      <= 1'b0;
            illegal <= 1'b0;
        end else if (valid_in) begin
            wr_en   <= !ill_d;
            result  <= res_d;
            zf      <= zf_d;
            cf      <= cf_d;
            illegal <= ill_d;
        end else begin
            wr_en   <= 1'b0;
            illegal <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_DONE);
endmodule

// File: rtl/bsc_checker.sv
module bsc_checker #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_in,
    input logic [1:0]        op_sel,
    input logic [1:0]        size,
    input logic              out_valid,
    input logic              wr_en,
    input logic [DATA_W-1:0] result,
    input logic              zf,
    input logic              cf,
    input logic              illegal
);
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> out_valid);
    assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !out_valid);
    assert_no_write_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !wr_en);
    assert_legal_writes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !illegal) |-> wr_en);
    assert_size_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && size == 2'b00) |=> illegal);
    assert_op_unused_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && op_sel == 2'b11) |=> illegal);
    assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wr_en && !zf && !cf && result == '0));
    assert_flag_pair_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(zf && cf));
endmodule

bind bitscan_unit bsc_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op_sel(op_sel),
    .size(size), .out_valid(out_valid), .wr_en(wr_en), .result(result),
    .zf(zf), .cf(cf), .illegal(illegal)
);

// File: tb/tb_bitscan_unit.sv
module tb_bitscan_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [1:0]  op_sel = '0, size = '0, pfx = '0;
    logic        feat_tz = 1'b0, feat_lz = 1'b0, feat_pop = 1'b0;
    logic [63:0] src = '0, dst_old = '0;
    logic        out_valid, wr_en, zf, cf, illegal;
    logic [63:0] result;

    int total = 0;
    int bad = 0;
    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bitscan_unit dut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op_sel(op_sel),
        .size(size), .pfx(pfx), .feat_tz(feat_tz), .feat_lz(feat_lz),
        .feat_pop(feat_pop), .src(src), .dst_old(dst_old),
        .out_valid(out_valid), .wr_en(wr_en), .result(result),
        .zf(zf), .cf(cf), .illegal(illegal)
    );

    function automatic logic [63:0] next_rand(input logic [63:0] v);
        logic [63:0] t;
        t = v ^ (v << 13);
        t = t ^ (t >> 7);
        t = t ^ (t << 17);
        return t;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h op=%0d size=%0d pfx=%0d feat=%b%b%b src=%h",
                     req, act, exp, op_sel, size, pfx, feat_tz, feat_lz, feat_pop, src);
        end
    endtask

    // Independent model of the requirements
    task automatic run_one(input logic [1:0] op, input logic [1:0] sz, input logic [1:0] pf,
                           input logic [2:0] ft, input logic [63:0] s, input logic [63:0] d);
        int w;
        logic [63:0] m, x, er;
        logic ez, ec, ei;
        int lo, hi;
        string tag;
        w  = (sz == 2'd0) ? 0 : (8 << sz);
        m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        x  = s & m;
        lo = -1;
        hi = -1;
        for (int i = 0; i < w; i++) begin
            if (x[i] && lo < 0) lo = i;
            if (x[i]) hi = i;
        end
        er = '0; ez = 0; ec = 0; ei = 0;
        if (sz == 2'd0 || op == 2'd3 || (op == 2'd2 && !(pf == 2'd2 && ft[0]))) begin
            ei = 1; tag = "R10";
        end else if (op == 2'd2) begin
            er = 64'($countones(x)); ez = (x == 0); tag = "R9";
        end else if (op == 2'd0 && pf == 2'd2 && ft[2]) begin
            er = (x == 0) ? 64'(w) : 64'(lo); ec = (x == 0); ez = (er == 0); tag = "R6";
        end else if (op == 2'd1 && pf == 2'd2 && ft[1]) begin
            er = (x == 0) ? 64'(w) : 64'(w - 1 - hi); ec = (x == 0); ez = (er == 0); tag = "R7";
        end else begin
            ez = (x == 0);
            if (x == 0) begin er = d & m; tag = "R5"; end
            else if (op == 2'd0) begin er = 64'(lo); tag = (pf == 2'd2) ? "R8" : "R3"; end
            else begin er = 64'(hi); tag = (pf == 2'd2) ? "R8" : "R4"; end
        end
        @(negedge clk);
        op_sel = op; size = sz; pfx = pf;
        feat_tz = ft[2]; feat_lz = ft[1]; feat_pop = ft[0];
        src = s; dst_old = d; valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
        check("R2", {63'd0, out_valid}, 64'd1);
        check({tag, " result R1"}, result, er);
        check({tag, " zf"}, {63'd0, zf}, {63'd0, ez});
        check({tag, " cf R11"}, {63'd0, cf}, {63'd0, ec});
        check({tag, " illegal"}, {63'd0, illegal}, {63'd0, ei});
        check({tag, " wr_en R2"}, {63'd0, wr_en}, {63'd0, !ei});
    endtask

    task automatic sweep_ctrl(input logic [1:0] sz, input logic [63:0] s);
        lfsr = next_rand(lfsr);
        for (int op = 0; op < 4; op++)
            for (int pf = 0; pf < 4; pf++)
                for (int ft = 0; ft < 8; ft++)
                    run_one(2'(op), sz, 2'(pf), 3'(ft), s, lfsr);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset out_valid", {63'd0, out_valid}, 64'd0);
        check("R12 reset wr_en", {63'd0, wr_en}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 idle after reset", {63'd0, out_valid}, 64'd0);

        for (int sz = 1; sz < 4; sz++) begin
            int w;
            logic [63:0] junk;
            w = 8 << sz;
            junk = (w == 64) ? 64'd0 : ~((64'd1 << w) - 64'd1);
            for (int b = 0; b < w; b++) sweep_ctrl(2'(sz), (64'd1 << b) | junk);
            sweep_ctrl(2'(sz), junk);
            sweep_ctrl(2'(sz), '1);
            for (int r = 0; r < 6; r++) sweep_ctrl(2'(sz), next_rand(lfsr ^ 64'(r)));
        end
        sweep_ctrl(2'd0, 64'h0000_0000_0000_00F0);

        @(negedge clk);
        check("R12 back to idle", {63'd0, out_valid}, 64'd0);
        check("R2 no write idle", {63'd0, wr_en}, 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule